// File: doc/BRIEF.md
# Checked AES Column Mix and Round-Key Stage

This block performs the linear tail of an AES round on a full 128-bit state. It applies MixColumns to every column and then XORs in a 128-bit round key. In parallel it computes a concurrent error signature. For each column, the signature XORs together the column's input bytes, round-key bytes and result bytes. The MixColumns matrix (2,3,1,1) has a GF(2^8) column sum of one, so every column signature is zero when the datapath is healthy. A nonzero signature flags a fault without any predicted copy of the mixing logic.

The four byte-wide column signatures form a 32-bit raw flag. The raw flag is XOR-folded down to a parameterised width `ERR_W` (1 to 32). A 128-bit fault mask is XORed onto the result ahead of the checker, which lets a test or a fault campaign corrupt chosen result bits and watch the flag respond. With `REG_OUT=1` (the default), the result and the flag are registered together. With `REG_OUT=0`, both are purely combinational.

Top module: `aes_mixkey_checked`

## Requirements
- R1: `result_o` equals MixColumns(`state_i`) XOR `rkey_i` XOR `inject_i`. Byte (row r, column c) of every 128-bit word sits at bits [127-8*(4c+r) -: 8], so column c occupies bits [127-32c -: 32] with row 0 in its top byte.
- R2: MixColumns multiplies each column by the circulant matrix whose first row is (2,3,1,1). Arithmetic is in GF(2^8) reduced by x^8+x^4+x^3+x+1 (0x11B). As an example, input column db,13,53,45 with a zero key gives 8e,4d,a1,bc.
- R3: For every column, the XOR of the four mixed bytes equals the XOR of the four input bytes.
- R4: When `inject_i` is zero, `err_o` is all zero for any state and key.
- R5: When `inject_i` has exactly one bit set, `err_o` is nonzero.
- R6: The raw flag bit 8c+k is bit k of column c's signature. Bit i of `err_o` is the XOR of all raw flag bits whose index modulo `ERR_W` equals i.
- R7: With `REG_OUT=1`, the outputs show the inputs applied before the previous rising clock edge, a one-cycle latency. While `rst_n` is low, both outputs are zero.
- R8: For any mask, raw flag bit 8c+k equals the XOR over the four rows of bit k of the mask byte at (row, column c). In particular, two flipped bits in the same column and bit position cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| state_i | input | 128 | State entering MixColumns |
| rkey_i | input | 128 | Round key added after mixing |
| inject_i | input | 128 | Fault mask XORed onto the result before the checker |
| result_o | output | 128 | Mixed and keyed state, including any injected flips |
| err_o | output | ERR_W | Folded error-indication flag |

## Verification
The subtle case is a multi-bit fault whose flips cancel: two flips at the same bit position within one column. Folding can also make flips in different columns meet in one flag bit. The bench walks all 128 single-bit masks to cover every signature lane. It then drives crafted pairs that share a column and bit, plus pairs that collide only after folding. It uses `ERR_W=5`, which does not divide 32, so the fold wraps unevenly and the expected flag is computed exactly for each mask.

// File: rtl/aes_mck_pkg.sv
package aes_mck_pkg;

  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int COL_W  = BYTE_W * ROWS;

  // Multiply by x in GF(2^8) with reduction polynomial 0x11B.
  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  // One column through the (2,3,1,1) circulant; row 0 is the top byte.
  function automatic logic [31:0] mix_one_col(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] y0, y1, y2, y3;
    a0 = col[31:24];
    a1 = col[23:16];
    a2 = col[15:8];
    a3 = col[7:0];
    y0 = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
    y1 = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
    y2 = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
    y3 = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
    return {y0, y1, y2, y3};
  endfunction

  // XOR of the four bytes of a column.
  function automatic logic [7:0] col_byte_sum(input logic [31:0] col);
    return col[31:24] ^ col[23:16] ^ col[15:8] ^ col[7:0];
  endfunction

endpackage

// File: rtl/mck_column.sv
module mck_column
  import aes_mck_pkg::*;
(
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);

  logic [7:0] in_sum;
  logic [7:0] out_sum;

  assign col_out = mix_one_col(col_in);
  assign in_sum  = col_byte_sum(col_in);
  assign out_sum = col_byte_sum(col_out);

  // Matrix column sum is one, so mixing keeps the byte sum.
  always_comb begin
    assert_colsum_kept_R3: assert (in_sum == out_sum)
      else $error("column byte sum changed by mixing");
  end

endmodule

// File: rtl/mck_colsig.sv
module mck_colsig
  import aes_mck_pkg::*;
(
  input  logic [COL_W-1:0]  mix_in,
  input  logic [COL_W-1:0]  key_in,
  input  logic [COL_W-1:0]  res_in,
  output logic [BYTE_W-1:0] sig
);

  assign sig = col_byte_sum(mix_in) ^ col_byte_sum(key_in) ^ col_byte_sum(res_in);

endmodule

// File: rtl/mck_fold.sv
module mck_fold #(
  parameter int RAW_W = 32,
  parameter int OUT_W = 8
) (
  input  logic [RAW_W-1:0] raw,
  output logic [OUT_W-1:0] folded
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_lane
    always_comb begin
      folded[i] = 1'b0;
      for (int j = i; j < RAW_W; j += OUT_W) folded[i] = folded[i] ^ raw[j];
    end
  end

  // Folding keeps the overall parity of the raw flag.
  always_comb begin
    assert_fold_parity_R6: assert ((^folded) == (^raw))
      else $error("fold changed raw flag parity");
  end

endmodule

// File: rtl/aes_mixkey_checked.sv
module aes_mixkey_checked
  import aes_mck_pkg::*;
#(
  parameter int ERR_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [127:0]       state_i,
  input  logic [127:0]       rkey_i,
  input  logic [127:0]       inject_i,
  output logic [127:0]       result_o,
  output logic [ERR_W-1:0]   err_o
);

  localparam int NCOL    = 4;
  localparam int STATE_W = NCOL * COL_W;
  localparam int RAW_W   = NCOL * BYTE_W;

  logic [STATE_W-1:0] mixed;
  logic [STATE_W-1:0] result_c;
  logic [RAW_W-1:0]   raw_flag;
  logic [ERR_W-1:0]   err_c;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int LO = COL_W * (NCOL - 1 - c);

    mck_column u_mix (
      .col_in  (state_i[LO +: COL_W]),
      .col_out (mixed[LO +: COL_W])
    );

    mck_colsig u_sig (
      .mix_in (state_i[LO +: COL_W]),
      .key_in (rkey_i[LO +: COL_W]),
      .res_in (result_c[LO +: COL_W]),
      .sig    (raw_flag[BYTE_W*c +: BYTE_W])
    );
  end

  assign result_c = mixed ^ rkey_i ^ inject_i;

  mck_fold #(.RAW_W(RAW_W), .OUT_W(ERR_W)) u_fold (
    .raw    (raw_flag),
    .folded (err_c)
  );

  always_comb begin
    if (rst_n) begin
      assert_clean_flag_R4: assert (inject_i != '0 || raw_flag == '0)
        else $error("signature nonzero without injection");
      assert_single_detect_R5: assert ($countones(inject_i) != 1 || raw_flag != '0)
        else $error("single flipped bit not detected");
    end
  end

  if (REG_OUT) begin : g_reg
    logic [STATE_W-1:0] res_q;
    logic [ERR_W-1:0]   err_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q <= '0;
        err_q <= '0;
      end else begin
        res_q <= result_c;
        err_q <= err_c;
      end
    end

    assign result_o = res_q;
    assign err_o    = err_q;

    assert_clean_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_i == '0) |=> (err_o == '0))
      else $error("registered flag nonzero after clean cycle");
  end else begin : g_comb
    assign result_o = result_c;
    assign err_o    = err_c;
  end

endmodule

// File: tb/aes_mixkey_checked_tb.sv
module aes_mixkey_checked_tb;

  localparam int CLK_P = 10;
  localparam int EW    = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [127:0]   state_i = '0;
  logic [127:0]   rkey_i = '0;
  logic [127:0]   inject_i = '0;
  logic [127:0]   result_o;
  logic [EW-1:0]  err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [127:0]  exp_res;
  logic [EW-1:0] exp_err;
  bit            pend = 1'b0;
  string         pend_tag;
  bit            pend_single = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  aes_mixkey_checked #(.ERR_W(EW), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .rkey_i(rkey_i),
    .inject_i(inject_i), .result_o(result_o), .err_o(err_o)
  );

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) p = p ^ a;
      a = a << 1;
      if (a & 'h100) a = a ^ 'h11B;
    end
    return p & 'hFF;
  endfunction

  function automatic int get_b(logic [127:0] s, int r, int c);
    return int'(s[127 - 8*(4*c + r) -: 8]);
  endfunction

  function automatic logic [127:0] ref_mix(logic [127:0] s);
    int coef[4] = '{2, 3, 1, 1};
    logic [127:0] o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        int acc = 0;
        for (int k = 0; k < 4; k++) acc = acc ^ gmul(get_b(s, k, c), coef[(k - r + 4) % 4]);
        o[127 - 8*(4*c + r) -: 8] = acc[7:0];
      end
    return o;
  endfunction

  function automatic logic [EW-1:0] ref_err(logic [127:0] m);
    logic [EW-1:0] f = '0;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 8; k++) begin
        int bitv = 0;
        for (int r = 0; r < 4; r++) bitv = bitv ^ ((get_b(m, r, c) >> k) & 1);
        f[(8*c + k) % EW] = f[(8*c + k) % EW] ^ bitv[0];
      end
    return f;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Compare the pending expectation, then apply new inputs.
  task automatic step(logic [127:0] s, logic [127:0] k, logic [127:0] m, string tag);
    @(negedge clk);
    if (pend) begin
      chk(result_o == exp_res, pend_tag, "result", result_o, exp_res);
      chk(err_o == exp_err, pend_tag, "err", 128'(err_o), 128'(exp_err));
      if (pend_single) chk(err_o != '0, "R5", "single flip seen", 128'(err_o), 128'(1));
    end
    state_i = s; rkey_i = k; inject_i = m;
    exp_res = ref_mix(s) ^ k ^ m;
    exp_err = ref_err(m);
    pend = 1'b1;
    pend_tag = tag;
    pend_single = ($countones(m) == 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] s, k, m, mx;
    // R7: reset holds outputs at zero even with busy inputs
    state_i = {4{32'hDEADBEEF}}; rkey_i = {4{32'h12345678}}; inject_i = 128'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result_o == '0, "R7", "result in reset", result_o, '0);
    chk(err_o == '0, "R7", "err in reset", 128'(err_o), '0);
    rst_n = 1'b1;

    // R2: known column, zero key
    step({32'hDB135345, 96'h0}, '0, '0, "R2");
    step('0, '0, '0, "R1");
    @(negedge clk);
    // outputs here show the zero vector; verify the known column one cycle earlier via model below
    state_i = {32'hDB135345, 96'h0}; rkey_i = '0; inject_i = '0; pend = 1'b0;
    @(negedge clk);
    chk(result_o[127:96] == 32'h8E4DA1BC, "R2", "known column", 128'(result_o[127:96]), 128'h8E4DA1BC);

    // R4/R1/R3: random clean vectors
    for (int i = 0; i < 40; i++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      step(s, k, '0, "R4");
      @(negedge clk);
      pend = 1'b0;
      chk(result_o == (ref_mix(s) ^ k), "R1", "mix plus key", result_o, ref_mix(s) ^ k);
      mx = ref_mix(s);
      for (int c = 0; c < 4; c++) begin
        int a = 0, b = 0;
        for (int r = 0; r < 4; r++) begin a = a ^ get_b(mx, r, c); b = b ^ get_b(s, r, c); end
        chk(a == b, "R3", "column byte sum", 128'(a), 128'(b));
      end
    end

    // R5/R6: every single-bit injection, back to back
    for (int i = 0; i < 128; i++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      step(s, k, 128'(1) << i, "R6");
    end

    // R8: cancelling pair (same column, same bit, different rows)
    step({$urandom, $urandom, $urandom, $urandom}, '0,
         (128'(1) << 127) | (128'(1) << 119), "R8");
    // R8: pair differing by 5 flag lanes, colliding after fold
    step({$urandom, $urandom, $urandom, $urandom}, '0,
         (128'(1) << 96) | (128'(1) << 101), "R8");
    for (int i = 0; i < 30; i++) begin
      m = {$urandom, $urandom, $urandom, $urandom};
      step({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, m, "R8");
    end

    // R7: mid-run reset clears the register
    @(negedge clk);
    pend = 1'b0;
    rst_n = 1'b0;
    inject_i = '1;
    @(negedge clk);
    chk(result_o == '0 && err_o == '0, "R7", "mid-run reset", result_o, '0);
    rst_n = 1'b1;
    step({$urandom, $urandom, $urandom, $urandom}, '0, '0, "R7");
    step('0, '0, '0, "R7");
    @(negedge clk);
    chk(result_o == '0 && err_o == '0, "R7", "flush", result_o, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule